// File: doc/BRIEF.md
# Branch Target Predictor for Instruction Fetch

This block owns the program counter of an instruction-fetch stage and guesses where simple direct branches go. A table indexed by address bits holds, for each slot, the upper bits of a branch's own address, the address it jumps to, and a live bit. While the fetch stage steps forward through straight-line code, a slot that matches the address being fetched steers the following fetch to the stored destination. That following fetch is then marked as a predicted-taken branch. When no slot matches, the next word follows in sequence and carries no mark, so a later decoder can still apply its own static guess.

A later execute stage reports each resolved branch. For a branch whose destination is encoded in the instruction itself, the report rewrites the slot. The live bit copies the taken outcome, so a branch that fell through removes its own prediction. The table is read two words ahead of the current fetch address to keep the memory read off the critical path. Because of this, the first two sequential fetches after any change of flow can never be predicted.

Top module: `btc_fetch`

## Requirements
- R1: Reset places the fetch address at `RESET_ADDR`, clears the predicted flag and invalidates every slot, so no fetch is predicted until a new taken report arrives.
- R2: With no redirect and no hit, an advance moves the fetch address up by 4 with the flag low. With advance low and no redirect, the address and flag hold, and the read-ahead pipeline keeps its contents.
- R3: A redirect sets the next fetch address to the redirect address with the flag low, whatever the advance input or the table hold.
- R4: When the current fetch address equals a slot's stored branch address and that slot is live, an advance makes the next fetch address the stored destination and raises the flag.
- R5: The first and second sequential fetches after a redirect, a reset or a predicted jump never produce a hit. The third one can.
- R6: A report with valid and eligible set writes slot `res_pc_i[INDEX_W+1:2]` with the branch address and destination. The live bit becomes the taken input, so a not-taken report cancels an earlier prediction.
- R7: A report with eligible low, meaning a branch through a register, leaves the table unchanged. An existing prediction keeps its destination, and an empty slot stays empty.
- R8: The table is direct-mapped with a full address compare. A branch that shares an index with an older entry replaces it, and the older address then misses.
- R9: If a report and a read-ahead hit the same slot in the same cycle, the read returns the contents from before the write.
- R10: With `ENABLE` = 0 the table is absent. The flag stays low and the address only steps by 4 or follows redirects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_adv_i | input | 1 | Current fetch is consumed; move to the next address |
| redir_valid_i | input | 1 | Redirect from decode or execute |
| redir_addr_i | input | ADDR_W | Redirect destination |
| res_valid_i | input | 1 | A resolved branch report is present |
| res_direct_i | input | 1 | Reported branch has an instruction-encoded destination |
| res_taken_i | input | 1 | Reported branch was taken |
| res_pc_i | input | ADDR_W | Address of the reported branch |
| res_target_i | input | ADDR_W | Destination of the reported branch |
| fetch_addr_o | output | ADDR_W | Current fetch address (registered) |
| fetch_pred_o | output | 1 | Current fetch was reached by a predicted jump (registered) |

## Verification
The bench builds two instances side by side, one with `ENABLE` = 1 and one with `ENABLE` = 0, both with `INDEX_W` = 6, and drives them with identical stimulus. The 64-slot table, combined with addresses drawn from a 1 KiB window, gives each index four competing branch addresses. This makes evictions, aliasing misses and overwrites of live slots common in the random phase. The disabled copy runs alongside as a reference for plain sequential stepping.

// File: rtl/btc_pkg.sv
package btc_pkg;

  // Source of the next fetch address
  typedef enum logic [1:0] {
    NXT_HOLD  = 2'd0,
    NXT_SEQ   = 2'd1,
    NXT_TAKEN = 2'd2,
    NXT_REDIR = 2'd3
  } nxt_src_e;

  localparam int unsigned INSN_BYTES = 4;
  localparam int unsigned AHEAD_BYTES = 2 * INSN_BYTES;

endpackage

// File: rtl/btc_store.sv
module btc_store #(
  parameter int INDEX_W = 10,
  parameter int TAG_W   = 20,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [DATA_W-1:0]  wr_tgt,
  input  logic               wr_valid,
  input  logic               rd_en,
  input  logic [INDEX_W-1:0] rd_idx,
  output logic [TAG_W-1:0]   rd_tag,
  output logic [DATA_W-1:0]  rd_tgt,
  output logic               rd_valid
);

  localparam int DEPTH = 1 << INDEX_W;
  localparam int ROW_W = TAG_W + DATA_W;

  // Tag and destination live in a plain array with no reset (block RAM)
  logic [ROW_W-1:0] mem [DEPTH];
  logic [ROW_W-1:0] row_q;

  // Live bits are flops so that reset can clear them all at once
  logic [DEPTH-1:0] live_q;
  logic             live_rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= {wr_tag, wr_tgt};
    end
    if (rd_en) begin
      row_q <= mem[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
    end else if (wr_en) begin
      live_q[wr_idx] <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_rd_q <= 1'b0;
    end else if (rd_en) begin
      live_rd_q <= live_q[rd_idx];
    end
  end

  assign rd_tag   = row_q[ROW_W-1:DATA_W];
  assign rd_tgt   = row_q[DATA_W-1:0];
  assign rd_valid = live_rd_q;

endmodule

// File: rtl/btc_lookup.sv
module btc_lookup
  import btc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int INDEX_W = 10,
  localparam int TAG_W  = ADDR_W - INDEX_W - 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  input  logic               flush,
  input  logic [ADDR_W-1:0]  cur_pc,
  output logic [INDEX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0]   rd_tag,
  input  logic [ADDR_W-1:0]  rd_tgt,
  input  logic               rd_valid,
  output logic               hit,
  output logic [ADDR_W-1:0]  hit_tgt
);

  logic [ADDR_W-1:0] ahead;

  // Stage 1: address whose slot is being read from the store
  logic              s1_vld;
  logic [ADDR_W-1:0] s1_addr;

  // Stage 2: slot contents waiting for the fetch to reach that address
  logic              s2_vld;
  logic [ADDR_W-1:0] s2_addr;
  logic [TAG_W-1:0]  s2_tag;
  logic [ADDR_W-1:0] s2_tgt;
  logic              s2_live;

  assign ahead  = cur_pc + ADDR_W'(AHEAD_BYTES);
  assign rd_idx = ahead[INDEX_W+1:2];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      s1_vld <= 1'b0;
    end else if (adv) begin
      s1_vld <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s1_addr <= ahead;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      s2_vld <= 1'b0;
    end else if (adv) begin
      s2_vld <= s1_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s2_addr <= s1_addr;
      s2_tag  <= rd_tag;
      s2_tgt  <= rd_tgt;
      s2_live <= rd_valid;
    end
  end

  assign hit = s2_vld && s2_live && (s2_addr == cur_pc)
            && (s2_tag == cur_pc[ADDR_W-1:INDEX_W+2]);
  assign hit_tgt = s2_tgt;

endmodule

// File: rtl/btc_fetch.sv
module btc_fetch
  import btc_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter int              INDEX_W    = 10,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  parameter bit              ENABLE     = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_adv_i,
  input  logic              redir_valid_i,
  input  logic [ADDR_W-1:0] redir_addr_i,
  input  logic              res_valid_i,
  input  logic              res_direct_i,
  input  logic              res_taken_i,
  input  logic [ADDR_W-1:0] res_pc_i,
  input  logic [ADDR_W-1:0] res_target_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              fetch_pred_o
);

  localparam int TAG_W = ADDR_W - INDEX_W - 2;

  logic [ADDR_W-1:0] pc_q, pc_n;
  logic              pred_q, pred_n;
  logic              hit;
  logic [ADDR_W-1:0] hit_tgt;
  nxt_src_e          src;

  generate
    if (ENABLE) begin : g_btc
      logic               flush;
      logic [INDEX_W-1:0] rd_idx;
      logic [TAG_W-1:0]   rd_tag;
      logic [ADDR_W-1:0]  rd_tgt;
      logic               rd_valid;
      logic               wr_en;
      logic               unused_lsb;

      assign flush      = redir_valid_i || (fetch_adv_i && hit);
      assign wr_en      = res_valid_i && res_direct_i;
      assign unused_lsb = ^res_pc_i[1:0];

      btc_store #(
        .INDEX_W (INDEX_W),
        .TAG_W   (TAG_W),
        .DATA_W  (ADDR_W)
      ) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (res_pc_i[INDEX_W+1:2]),
        .wr_tag   (res_pc_i[ADDR_W-1:INDEX_W+2]),
        .wr_tgt   (res_target_i),
        .wr_valid (res_taken_i),
        .rd_en    (fetch_adv_i),
        .rd_idx   (rd_idx),
        .rd_tag   (rd_tag),
        .rd_tgt   (rd_tgt),
        .rd_valid (rd_valid)
      );

      btc_lookup #(
        .ADDR_W  (ADDR_W),
        .INDEX_W (INDEX_W)
      ) u_lookup (
        .clk      (clk),
        .rst      (rst),
        .adv      (fetch_adv_i),
        .flush    (flush),
        .cur_pc   (pc_q),
        .rd_idx   (rd_idx),
        .rd_tag   (rd_tag),
        .rd_tgt   (rd_tgt),
        .rd_valid (rd_valid),
        .hit      (hit),
        .hit_tgt  (hit_tgt)
      );
    end else begin : g_no_btc
      logic unused_res;
      assign unused_res = ^{res_valid_i, res_direct_i, res_taken_i,
                            res_pc_i, res_target_i};
      assign hit     = 1'b0;
      assign hit_tgt = '0;
    end
  endgenerate

  always_comb begin
    if (redir_valid_i)    src = NXT_REDIR;
    else if (!fetch_adv_i) src = NXT_HOLD;
    else if (hit)         src = NXT_TAKEN;
    else                  src = NXT_SEQ;
  end

  always_comb begin
    pc_n   = pc_q;
    pred_n = pred_q;
    case (src)
      NXT_REDIR: begin pc_n = redir_addr_i;                  pred_n = 1'b0; end
      NXT_TAKEN: begin pc_n = hit_tgt;                       pred_n = 1'b1; end
      NXT_SEQ:   begin pc_n = pc_q + ADDR_W'(INSN_BYTES);    pred_n = 1'b0; end
      default:   begin pc_n = pc_q;                          pred_n = pred_q; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= RESET_ADDR;
      pred_q <= 1'b0;
    end else begin
      pc_q   <= pc_n;
      pred_q <= pred_n;
    end
  end

  assign fetch_addr_o = pc_q;
  assign fetch_pred_o = pred_q;

endmodule

// File: rtl/btc_fetch_chk.sv
module btc_fetch_chk #(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  parameter bit                ENABLE     = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_adv_i,
  input logic              redir_valid_i,
  input logic [ADDR_W-1:0] redir_addr_i,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic              fetch_pred_o
);

  logic       rst_q;
  logic [1:0] seq_q;
  logic [1:0] seq_eff;

  // Position of the current fetch in its straight-line run
  assign seq_eff = fetch_pred_o ? 2'd0 : seq_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst || redir_valid_i) begin
      seq_q <= 2'd0;
    end else if (fetch_adv_i) begin
      seq_q <= (seq_eff == 2'd3) ? 2'd3 : seq_eff + 2'd1;
    end
  end

  // R1: one cycle into reset the outputs show the reset state
  always_ff @(posedge clk) begin
    if (rst_q) begin
      p_reset_state_r1: assert (fetch_addr_o == RESET_ADDR && !fetch_pred_o)
        else $error("reset state wrong");
    end
  end

  // R2
  p_hold_stall_r2: assert property (@(posedge clk) disable iff (rst)
    (!fetch_adv_i && !redir_valid_i) |=> ($stable(fetch_addr_o) && $stable(fetch_pred_o)));

  // R2
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (fetch_adv_i && !redir_valid_i) |=>
      (fetch_pred_o || fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(4)));

  // R3
  p_redirect_r3: assert property (@(posedge clk) disable iff (rst)
    redir_valid_i |=> (fetch_addr_o == $past(redir_addr_i) && !fetch_pred_o));

  // R5
  p_no_early_hit_r5: assert property (@(posedge clk) disable iff (rst)
    (fetch_adv_i && !redir_valid_i && seq_eff < 2'd2) |=> !fetch_pred_o);

  generate
    if (!ENABLE) begin : g_off
      // R10
      p_flag_off_r10: assert property (@(posedge clk) disable iff (rst)
        fetch_adv_i |=> !fetch_pred_o);
    end
  endgenerate

endmodule

bind btc_fetch btc_fetch_chk #(
  .ADDR_W     (ADDR_W),
  .RESET_ADDR (RESET_ADDR),
  .ENABLE     (ENABLE)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .fetch_adv_i   (fetch_adv_i),
  .redir_valid_i (redir_valid_i),
  .redir_addr_i  (redir_addr_i),
  .fetch_addr_o  (fetch_addr_o),
  .fetch_pred_o  (fetch_pred_o)
);

// File: tb/btc_fetch_tb.sv
module btc_fetch_tb;

  localparam int          AW = 32;
  localparam int          IB = 6;
  localparam int          NE = 1 << IB;
  localparam logic [31:0] RA = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv = 1'b0, rv = 1'b0, uv = 1'b0, ue = 1'b0, ut = 1'b0;
  logic [31:0] ra = '0, up = '0, utg = '0;
  logic [31:0] dut_addr, off_addr;
  logic        dut_pred, off_pred;

  int vecs = 0;
  int bad  = 0;
  bit done = 0;

  // Reference state
  logic        m_v [NE];
  logic [31:0] m_b [NE];
  logic [31:0] m_t [NE];
  logic [31:0] m_pc, o_pc;
  logic        m_pred;
  int          m_cnt;

  always #5 clk = ~clk;

  btc_fetch #(.ADDR_W(AW), .INDEX_W(IB), .RESET_ADDR(RA), .ENABLE(1'b1)) u_dut (
    .clk(clk), .rst(rst), .fetch_adv_i(adv), .redir_valid_i(rv), .redir_addr_i(ra),
    .res_valid_i(uv), .res_direct_i(ue), .res_taken_i(ut), .res_pc_i(up),
    .res_target_i(utg), .fetch_addr_o(dut_addr), .fetch_pred_o(dut_pred));

  btc_fetch #(.ADDR_W(AW), .INDEX_W(IB), .RESET_ADDR(RA), .ENABLE(1'b0)) u_off (
    .clk(clk), .rst(rst), .fetch_adv_i(adv), .redir_valid_i(rv), .redir_addr_i(ra),
    .res_valid_i(uv), .res_direct_i(ue), .res_taken_i(ut), .res_pc_i(up),
    .res_target_i(utg), .fetch_addr_o(off_addr), .fetch_pred_o(off_pred));

  function automatic int ix(logic [31:0] a);
    return int'(a[IB+1:2]);
  endfunction

  function automatic bit mhit(logic [31:0] a);
    return m_v[ix(a)] && (m_b[ix(a)] == a);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NE; i++) m_v[i] = 1'b0;
    m_pc = RA; o_pc = RA; m_pred = 1'b0; m_cnt = 0;
  endtask

  // One clock: drive at negedge, model the edge, compare at next negedge
  task automatic step(bit a, bit r, logic [31:0] rad, bit u, bit e, bit tk,
                      logic [31:0] bpc, logic [31:0] btg, bit mwr);
    string tag;
    adv = a; rv = r; ra = rad; uv = u; ue = e; ut = tk; up = bpc; utg = btg;
    @(posedge clk);
    if (r) begin
      m_pc = rad; m_pred = 1'b0; m_cnt = 0; tag = "R3";
    end else if (a) begin
      if (m_cnt >= 2 && mhit(m_pc)) begin
        m_pc = m_t[ix(m_pc)]; m_pred = 1'b1; m_cnt = 0; tag = "R4";
      end else begin
        tag = mhit(m_pc) ? "R5" : "R2";
        m_pc = m_pc + 4; m_pred = 1'b0;
        if (m_cnt < 3) m_cnt++;
      end
    end else begin
      tag = "R2";
    end
    if (r) o_pc = rad; else if (a) o_pc = o_pc + 4;
    if (u && e && mwr) begin
      m_v[ix(bpc)] = tk; m_b[ix(bpc)] = bpc; m_t[ix(bpc)] = btg;
    end
    @(negedge clk);
    uv = 1'b0; rv = 1'b0;
    chk(tag, dut_addr, m_pc);
    chk(tag, {31'd0, dut_pred}, {31'd0, m_pred});
    chk("R10", off_addr, o_pc);
    chk("R10", {31'd0, off_pred}, 32'd0);
  endtask

  task automatic upd(logic [31:0] bpc, logic [31:0] btg, bit e, bit tk);
    step(1'b0, 1'b0, '0, 1'b1, e, tk, bpc, btg, 1'b1);
  endtask

  task automatic jump(logic [31:0] a);
    step(1'b0, 1'b1, a, 1'b0, 1'b0, 1'b0, '0, '0, 1'b1);
  endtask

  task automatic go();
    step(1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, '0, 1'b1);
  endtask

  task automatic stall();
    step(1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, '0, 1'b1);
  endtask

  // Redirect two words before b and fetch through b
  task automatic run_to(logic [31:0] b);
    jump(b - 8);
    go(); go(); go();
  endtask

  task automatic do_reset();
    rst = 1'b1; adv = 1'b0; rv = 1'b0; uv = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    model_clear();
    chk("R1", dut_addr, RA);
    chk("R1", {31'd0, dut_pred}, 32'd0);
    rst = 1'b0;
  endtask

  function automatic logic [31:0] rnd_addr();
    return 32'h0000_1000 + ((32'($urandom) % 256) << 2);
  endfunction

  localparam logic [31:0] B  = 32'h0000_1040;
  localparam logic [31:0] T  = 32'h0000_1200;
  localparam logic [31:0] C  = 32'h0000_1080;
  localparam logic [31:0] A2 = B + 32'(NE * 4);

  initial begin : wd
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7357));
    @(negedge clk);
    do_reset();
    // R1: empty table, nothing predicted from reset address
    go(); go(); go(); go();
    chk("R1", {31'd0, dut_pred}, 32'd0);

    // R4 / R6: taken report creates a prediction
    upd(B, T, 1'b1, 1'b1);
    run_to(B);
    chk("R4", dut_addr, T);
    chk("R6", {31'd0, dut_pred}, 32'd1);
    go(); go();
    chk("R5", dut_addr, T + 8);

    // R6: not-taken report cancels it
    upd(B, T, 1'b1, 1'b0);
    run_to(B);
    chk("R6", dut_addr, B + 4);
    chk("R6", {31'd0, dut_pred}, 32'd0);

    // R7: ineligible reports change nothing
    upd(B, T, 1'b1, 1'b1);
    upd(B, 32'h0000_1300, 1'b0, 1'b1);
    upd(B, T, 1'b0, 1'b0);
    run_to(B);
    chk("R7", dut_addr, T);
    upd(C, T, 1'b0, 1'b1);
    run_to(C);
    chk("R7", dut_addr, C + 4);
    chk("R7", {31'd0, dut_pred}, 32'd0);

    // R8: alias evicts B
    upd(A2, 32'h0000_1280, 1'b1, 1'b1);
    run_to(B);
    chk("R8", dut_addr, B + 4);
    run_to(A2);
    chk("R8", dut_addr, 32'h0000_1280);
    chk("R8", {31'd0, dut_pred}, 32'd1);

    // R9: write and read-ahead of slot B on the same edge; read sees old data
    jump(B - 8);
    step(1'b1, 1'b0, '0, 1'b1, 1'b1, 1'b1, B, T, 1'b0);
    go(); go();
    chk("R9", dut_addr, B + 4);
    chk("R9", {31'd0, dut_pred}, 32'd0);
    m_v[ix(B)] = 1'b1; m_b[ix(B)] = B; m_t[ix(B)] = T;
    run_to(B);
    chk("R9", dut_addr, T);

    // R2 / R5: stalls keep the read-ahead
    jump(B - 8);
    go(); stall(); stall(); go(); stall(); go();
    chk("R2", dut_addr, T);
    chk("R2", {31'd0, dut_pred}, 32'd1);

    // R1: reset forgets all entries
    do_reset();
    run_to(B);
    chk("R1", dut_addr, B + 4);
    chk("R1", {31'd0, dut_pred}, 32'd0);

    // Random rounds
    for (int rnd = 0; rnd < 40; rnd++) begin
      for (int k = 0; k < 8; k++) begin
        upd(rnd_addr(), rnd_addr(), ($urandom % 4) != 0, ($urandom % 3) != 0);
      end
      jump(rnd_addr());
      for (int k = 0; k < 60; k++) begin
        int sel = int'($urandom % 16);
        if (sel == 0) jump(rnd_addr());
        else if (sel < 4) stall();
        else if (sel == 4) step(1'b1, 1'b1, rnd_addr(), 1'b0, 1'b0, 1'b0, '0, '0, 1'b1);
        else go();
      end
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule